// File: doc/BRIEF.md
# Video DAC Input Register and Code Formatter

This block is the clocked digital front end of a 10-bit video-rate digital-to-analog converter. On every rising clock edge it registers a data word together with three active-low controls. From the registered values it then forms the code that drives the converter's current switches. In that code, all ones turns every switch on (full scale) and all zeros turns every switch off (zero scale).

The controls let the same word be read in one of four ways: unsigned, unsigned inverted, signed (two's complement), or signed inverted. A calibration step can also pin the output at either end of the range. The full-scale force turns on every switch, even when the system drives only the upper 8 or 9 data bits. A separate active-low disable acts at once, without waiting for the clock, and holds all switches off.

The disable does not touch the register. When it is released, the last captured code returns straight away.

Top module: `dac_fmt_front`

## Requirements
- R1: While `rst_n` is low, `sw_code` is all zeros. This holds at once, even in the middle of a run, because reset clears the data register and sets the three control registers to their inactive (high) level.
- R2: With `n2c_n`, `nfh_n` and `nfl_n` all high and `ndis_n` high, `sw_code` equals the data word captured at the previous rising edge. The code is unsigned binary, and bit 9 is the most significant bit.
- R3: With `n2c_n` low and both force inputs high, `sw_code` is the captured word with bit 9 inverted. So 0x1FF gives 0x3FF (full scale) and 0x200 gives 0x000 (zero scale).
- R4: With `nfh_n` low and `nfl_n` high at the capturing edge, `sw_code` is 0x3FF (all ten bits one), whatever the data and `n2c_n` are.
- R5: With `nfl_n` low and `nfh_n` high at the capturing edge, `sw_code` is 0x000, whatever the data and `n2c_n` are.
- R6: With `nfh_n` and `nfl_n` both low, no level is forced and all ten bits of the captured word are inverted. If `n2c_n` is also low, bit 9 is inverted once more, which gives inverse two's complement: 0x1FF gives 0x000 and 0x200 gives 0x3FF.
- R7: Whenever `ndis_n` is low, `sw_code` is 0x000. This takes effect between clock edges, with no clock edge needed.
- R8: Releasing `ndis_n` brings back, without a clock edge, the code formed from the values captured last. The disable never clears the register.
- R9: A change on `data`, `n2c_n`, `nfh_n` or `nfl_n` has no effect on `sw_code` until the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| data | input | 10 | Sample word, bit 9 most significant |
| n2c_n | input | 1 | Low: read the word as two's complement |
| nfh_n | input | 1 | Low alone: force full scale; low together with `nfl_n`: invert the word |
| nfl_n | input | 1 | Low alone: force zero scale; low together with `nfh_n`: invert the word |
| ndis_n | input | 1 | Asynchronous active-low disable, gives an all-zeros code |
| sw_code | output | 10 | Current-switch code, all ones is full scale |

## Verification
Two of the block's functions can act in the same cycle. The disable is combinational and acts between edges, while the clocked format and force path can change the code at an edge. The bench provokes the overlap by dropping `ndis_n` half a cycle after a capture, checking for zeros a fraction of a nanosecond later, and releasing it before the next edge. The code must then show the captured value again, still before any edge. In a second pattern, the disable is held low across edges while the format and force controls keep changing. The scoreboard expects zeros on every one of those cycles, and expects the new code to appear as soon as the disable rises.

// File: rtl/dac_fmt_pkg.sv
`timescale 1ns/100ps
package dac_fmt_pkg;

  // What the pair of force controls requests once registered.
  typedef enum logic [1:0] {
    FRC_NONE   = 2'd0,
    FRC_HIGH   = 2'd1,
    FRC_LOW    = 2'd2,
    FRC_INVERT = 2'd3
  } force_e;

  // Registered control set, all active low.
  typedef struct packed {
    logic tc_n;
    logic hi_n;
    logic lo_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{tc_n: 1'b1, hi_n: 1'b1, lo_n: 1'b1};

  function automatic force_e decode_force(input logic hi_n, input logic lo_n);
    case ({hi_n, lo_n})
      2'b00:   return FRC_INVERT;
      2'b01:   return FRC_HIGH;
      2'b10:   return FRC_LOW;
      default: return FRC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dac_rst_sync.sv
`timescale 1ns/100ps
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_in_reg.sv
`timescale 1ns/100ps
module dac_in_reg
  import dac_fmt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_s_n,
  input  logic [W-1:0] data,
  input  logic         n2c_n,
  input  logic         nfh_n,
  input  logic         nfl_n,
  output logic [W-1:0] word_q,
  output ctl_t         ctl_q
);
  logic [W-1:0] word_d;
  ctl_t         ctl_d;

  always_comb begin
    word_d     = data;
    ctl_d.tc_n = n2c_n;
    ctl_d.hi_n = nfh_n;
    ctl_d.lo_n = nfl_n;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      word_q <= '0;
      ctl_q  <= CTL_IDLE;
    end else begin
      word_q <= word_d;
      ctl_q  <= ctl_d;
    end
  end
endmodule

// File: rtl/dac_code_map.sv
`timescale 1ns/100ps
module dac_code_map
  import dac_fmt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] word_q,
  input  ctl_t         ctl_q,
  output logic [W-1:0] code
);
  localparam int MSB = W - 1;

  force_e       frc;
  logic         inv;
  logic         tc;
  logic [W-1:0] shaped;

  assign frc = decode_force(ctl_q.hi_n, ctl_q.lo_n);
  assign inv = (frc == FRC_INVERT);
  assign tc  = ~ctl_q.tc_n;

  // Inversion applies to every bit; the sign flip only to the top bit.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == MSB) begin : g_msb
      assign shaped[i] = word_q[i] ^ inv ^ tc;
    end else begin : g_low
      assign shaped[i] = word_q[i] ^ inv;
    end
  end

  always_comb begin
    case (frc)
      FRC_HIGH: code = '1;
      FRC_LOW:  code = '0;
      default:  code = shaped;
    endcase
  end
endmodule

// File: rtl/dac_fmt_front.sv
`timescale 1ns/100ps
module dac_fmt_front
  import dac_fmt_pkg::*;
#(
  parameter int W         = 10,
  parameter int RST_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data,
  input  logic         n2c_n,
  input  logic         nfh_n,
  input  logic         nfl_n,
  input  logic         ndis_n,
  output logic [W-1:0] sw_code
);
  logic         rst_s;
  logic [W-1:0] word_q;
  ctl_t         ctl_q;
  logic [W-1:0] code;

  dac_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s)
  );

  dac_in_reg #(.W(W)) u_reg (
    .clk     (clk),
    .rst_s_n (rst_s),
    .data    (data),
    .n2c_n   (n2c_n),
    .nfh_n   (nfh_n),
    .nfl_n   (nfl_n),
    .word_q  (word_q),
    .ctl_q   (ctl_q)
  );

  dac_code_map #(.W(W)) u_map (
    .word_q (word_q),
    .ctl_q  (ctl_q),
    .code   (code)
  );

  // Asynchronous disable: gates the code, leaves the register alone.
  assign sw_code = ndis_n ? code : '0;
endmodule

// File: rtl/dac_fmt_front_chk.sv
`timescale 1ns/100ps
module dac_fmt_front_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_s,
  input logic [W-1:0] data,
  input logic         n2c_n,
  input logic         nfh_n,
  input logic         nfl_n,
  input logic         ndis_n,
  input logic [W-1:0] sw_code
);
  localparam logic [W-1:0] TOPBIT = {1'b1, {(W-1){1'b0}}};

  logic armed;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!armed)
    !ndis_n |-> sw_code == '0); // R7
  AST_STRAIGHT: assert property (@(posedge clk) disable iff (!armed)
    ndis_n && $past(n2c_n && nfh_n && nfl_n) |-> sw_code == $past(data)); // R2
  AST_TWOS_FLIP: assert property (@(posedge clk) disable iff (!armed)
    ndis_n && $past(!n2c_n && nfh_n && nfl_n) |-> sw_code == ($past(data) ^ TOPBIT)); // R3
  AST_FORCE_FULL: assert property (@(posedge clk) disable iff (!armed)
    ndis_n && $past(!nfh_n && nfl_n) |-> sw_code == '1); // R4
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!armed)
    ndis_n && $past(nfh_n && !nfl_n) |-> sw_code == '0); // R5
  AST_BOTH_INVERT: assert property (@(posedge clk) disable iff (!armed)
    ndis_n && $past(!nfh_n && !nfl_n) |->
      sw_code == ~($past(data) ^ ($past(n2c_n) ? '0 : TOPBIT))); // R6
endmodule

bind dac_fmt_front dac_fmt_front_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_s   (rst_s),
  .data    (data),
  .n2c_n   (n2c_n),
  .nfh_n   (nfh_n),
  .nfl_n   (nfl_n),
  .ndis_n  (ndis_n),
  .sw_code (sw_code)
);

// File: tb/sim_dac_fmt_front.sv
`timescale 1ns/100ps
module sim_dac_fmt_front;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] data;
  logic         n2c_n, nfh_n, nfl_n, ndis_n;
  logic [W-1:0] sw_code;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [W-1:0] q_exp[$];
  int           q_tag[$];
  logic [W-1:0] last_exp;

  always #2.5 clk = ~clk;

  dac_fmt_front u0 (
    .clk(clk), .rst_n(rst_n), .data(data), .n2c_n(n2c_n),
    .nfh_n(nfh_n), .nfl_n(nfl_n), .ndis_n(ndis_n), .sw_code(sw_code)
  );

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Code formed from a captured set of inputs, taken from the requirements.
  function automatic logic [W-1:0] fmt_code(input logic [W-1:0] d, input logic tc_n,
                                            input logic hi_n, input logic lo_n);
    logic [W-1:0] v;
    if (!hi_n && lo_n)      v = '1;
    else if (hi_n && !lo_n) v = '0;
    else begin
      v = d;
      if (!hi_n && !lo_n) v = ~v;
      if (!tc_n) v[W-1] = ~v[W-1];
    end
    return v;
  endfunction

  function automatic int pick_tag(input logic tc_n, input logic hi_n,
                                  input logic lo_n, input logic dis_n);
    if (!dis_n)          return 7;
    if (!hi_n && !lo_n)  return 6;
    if (!hi_n)           return 4;
    if (!lo_n)           return 5;
    if (!tc_n)           return 3;
    return 2;
  endfunction

  task automatic check(input int t, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: sw_code=%h expected %h at %0t", tag_name(t), act, exp, $time);
    end
  endtask

  // Driver: applies one set of inputs and queues the result it must produce.
  task automatic drive(input logic [W-1:0] d, input logic tc_n, input logic hi_n,
                       input logic lo_n, input logic dis_n);
    logic [W-1:0] c;
    @(negedge clk);
    data = d; n2c_n = tc_n; nfh_n = hi_n; nfl_n = lo_n; ndis_n = dis_n;
    c = fmt_code(d, tc_n, hi_n, lo_n);
    if (dis_n) last_exp = c;
    q_exp.push_back(dis_n ? c : '0);
    q_tag.push_back(pick_tag(tc_n, hi_n, lo_n, dis_n));
  endtask

  // Monitor: the code from an edge's capture is compared just after that edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) check(q_tag.pop_front(), sw_code, q_exp.pop_front());
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; data = 10'h2A5; n2c_n = 1'b1; nfh_n = 1'b0; nfl_n = 1'b1; ndis_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(1, sw_code, '0); // R1 code cleared during reset despite a full-scale force
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Corner words under each control combination, then random words.
    for (int m = 0; m < 16; m++) begin
      logic [W-1:0] corners [4];
      corners[0] = 10'h000; corners[1] = 10'h1FF; corners[2] = 10'h200; corners[3] = 10'h3FF;
      for (int k = 0; k < 4; k++)
        drive(corners[k], m[0], m[1], m[2], m[3]);
      for (int k = 0; k < 8; k++)
        drive(W'($urandom), m[0], m[1], m[2], m[3]);
    end

    // R3 and R6 mapping of the signed extremes, stated explicitly.
    drive(10'h1FF, 1'b0, 1'b1, 1'b1, 1'b1);
    drive(10'h200, 1'b0, 1'b1, 1'b1, 1'b1);
    drive(10'h1FF, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(10'h200, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;

    // R9: inputs changed between edges leave the code alone until the edge.
    for (int k = 0; k < 4; k++) begin
      drive(W'($urandom), 1'b1, 1'b1, 1'b1, 1'b1);
      @(posedge clk); #1;
      @(negedge clk);
      data = ~data; nfh_n = k[0]; nfl_n = k[1]; n2c_n = 1'b0;
      #1 check(9, sw_code, last_exp); // R9
      @(posedge clk); #1;
    end

    // R7/R8: disable pulse between edges, then release before the next edge.
    for (int k = 0; k < 6; k++) begin
      drive(W'($urandom), k[0], k[1], k[2] & k[1], 1'b1);
      @(posedge clk); #1;
      @(negedge clk);
      #0.5 ndis_n = 1'b0;
      #0.5 check(7, sw_code, '0);         // R7 immediate zero
      #0.5 ndis_n = 1'b1;
      #0.5 check(8, sw_code, last_exp);   // R8 previous code returns
    end

    // R7/R8 across edges: disable held while formats change, then released.
    drive(10'h155, 1'b1, 1'b1, 1'b1, 1'b0);
    drive(10'h0F0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(10'h0F0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    @(negedge clk);
    #0.5 ndis_n = 1'b1;
    #0.5 check(8, sw_code, 10'h3FF); // R8 force-high captured while disabled

    // R1: reset asserted mid-run clears the code at once.
    drive(10'h3C3, 1'b1, 1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5 check(1, sw_code, '0); // R1
    @(negedge clk) begin
      rst_n = 1'b1; data = 10'h000; n2c_n = 1'b1; nfh_n = 1'b1; nfl_n = 1'b1;
    end
    repeat (4) @(posedge clk);
    #1 check(1, sw_code, '0); // R1 after release with idle inputs

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule